// File: doc/BRIEF.md
# Sparse-Tree Conditional-Sum Adder

This block adds two 108-bit unsigned operands and a carry-in, giving a 108-bit sum and a carry-out. It is split into twelve 9-bit slices. For each slice, a conditional-sum unit forms two candidate results: one for an incoming carry of 0 and one for an incoming carry of 1. Inside each unit a small logarithmic lookahead network forms the carries, so no carry ripples from bit to bit. The carry tree is sparse: it forms a carry only at slice boundaries, meaning bit 9, bit 18 and every ninth bit after that.

The sparse carries come from three 36-bit lookahead blocks. Each block takes the group generate and propagate terms of its four slices. It hands a block-level generate and propagate pair to the next block, which uses it to form the carry between blocks. A final select stage uses the carry entering each slice to pick that slice's candidate. The lowest slice is selected directly by the external carry-in.

The datapath is combinational. A parameter can place a register on the result. When that register is present, the result of the operands sampled at one rising clock edge appears right after that edge, and an active-low asynchronous reset clears it.

Top module: `sct_adder`

## Requirements
- R1: `sum` equals the low 108 bits of a + b + cin, with operands taken as unsigned.
- R2: `cout` equals bit 108 of the 109-bit value a + b + cin.
- R3: The lowest 9-bit slice (bits 8..0) selects its carry-1 candidate exactly when `cin` is 1.
- R4: For every slice, the carry-1 candidate equals the carry-0 candidate plus one, modulo 2^9.
- R5: The carry entering slice k (bits 9k+8..9k) equals the carry out of bit 9k-1 of the full addition. For example, a carry-in of 1 added to a value whose low 9k bits are all ones gives exactly bit 9k set.
- R6: The carry entering each 36-bit block at bits 36 and 72 is formed from the previous block's group generate and propagate pair, and equals the carry of the full addition at that position.
- R7: While `rst_n` is low, the registered `sum` and `cout` are zero.
- R8: A carry-in of 1 added to all-ones and zero propagates through all 108 bits, giving `sum` = 0 and `cout` = 1.
- R9: With the output register enabled, `sum` and `cout` change only at a rising clock edge, and they reflect the operands sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst_n | input | 1 | Active-low asynchronous reset of the result register |
| a | input | 108 | First operand |
| b | input | 108 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 108 | Low 108 bits of the result |
| cout | output | 1 | Carry out of bit 107 |

## Verification
The bench builds the adder with its default parameters: 108 bits, 9-bit slices, 36-bit lookahead blocks and the output register enabled. This places eleven interior slice boundaries and two block boundaries where the stimulus can aim a single carry. It also places one register stage between the operands and the result, so the one-cycle latency and the hold between edges can be observed. At every slice boundary the stimulus places a propagate run that ends exactly at that boundary. This shows each sparse carry, and each link between blocks, separately from random data.

// File: rtl/sct_pkg.sv
package sct_pkg;

  // generate / propagate pair of a bit group
  typedef struct packed {
    logic g;
    logic p;
  } sct_gp_t;

  // combine a more significant group (hi) with the group just below it (lo)
  function automatic sct_gp_t sct_merge(input sct_gp_t hi, input sct_gp_t lo);
    sct_gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

  // carry leaving a group, given the carry entering it
  function automatic logic sct_carry(input sct_gp_t grp, input logic c_in);
    return grp.g | (grp.p & c_in);
  endfunction

endpackage

// File: rtl/sct_cond_sum.sv
module sct_cond_sum
  import sct_pkg::*;
#(
  parameter int SLICE = 9
) (
  input  logic [SLICE-1:0] a,
  input  logic [SLICE-1:0] b,
  output logic [SLICE-1:0] sum0,
  output logic [SLICE-1:0] sum1,
  output sct_gp_t          grp
);

  localparam int LEVELS = (SLICE > 1) ? $clog2(SLICE) : 1;

  logic [SLICE-1:0] bit_g, bit_p;
  sct_gp_t [LEVELS:0][SLICE-1:0] pre;
  logic [SLICE-1:0] carry0, carry1;

  assign bit_g = a & b;
  assign bit_p = a ^ b;

  // logarithmic lookahead inside the slice: pre[LEVELS][i] covers bits i..0
  always_comb begin
    for (int i = 0; i < SLICE; i++) begin
      pre[0][i].g = bit_g[i];
      pre[0][i].p = bit_p[i];
    end
    for (int l = 0; l < LEVELS; l++) begin
      for (int i = 0; i < SLICE; i++) begin
        if (i >= (1 << l)) pre[l+1][i] = sct_merge(pre[l][i], pre[l][i-(1<<l)]);
        else               pre[l+1][i] = pre[l][i];
      end
    end
  end

  always_comb begin
    carry0[0] = 1'b0;
    carry1[0] = 1'b1;
    for (int i = 1; i < SLICE; i++) begin
      carry0[i] = pre[LEVELS][i-1].g;
      carry1[i] = sct_carry(pre[LEVELS][i-1], 1'b1);
    end
  end

  assign sum0 = bit_p ^ carry0;
  assign sum1 = bit_p ^ carry1;
  assign grp  = pre[LEVELS][SLICE-1];

  always_comb begin
    AST_CAND_STEP: assert (sum1 == sum0 + SLICE'(1)); // R4
  end

endmodule

// File: rtl/sct_lookahead_blk.sv
module sct_lookahead_blk
  import sct_pkg::*;
#(
  parameter int NSUB = 4
) (
  input  sct_gp_t [NSUB-1:0] sub_gp,
  input  logic               blk_cin,
  output logic [NSUB-1:0]    sub_cin,
  output sct_gp_t            blk_gp
);

  // each slice carry is formed from its own prefix, independent of the others
  always_comb begin
    for (int k = 0; k < NSUB; k++) begin
      sct_gp_t acc;
      if (k == 0) begin
        sub_cin[k] = blk_cin;
      end else begin
        acc = sub_gp[0];
        for (int j = 1; j < k; j++) acc = sct_merge(sub_gp[j], acc);
        sub_cin[k] = sct_carry(acc, blk_cin);
      end
    end
  end

  always_comb begin
    blk_gp = sub_gp[0];
    for (int j = 1; j < NSUB; j++) blk_gp = sct_merge(sub_gp[j], blk_gp);
  end

  // a block that generates must report a carry out whatever enters it
  always_comb begin
    if (blk_gp.g)
      AST_BLK_GEN: assert (sct_carry(sub_gp[NSUB-1], sub_cin[NSUB-1])); // R6
  end

endmodule

// File: rtl/sct_final_select.sv
module sct_final_select #(
  parameter int SLICE = 9,
  parameter int NS    = 12
) (
  input  logic [NS-1:0][SLICE-1:0] cand0,
  input  logic [NS-1:0][SLICE-1:0] cand1,
  input  logic [NS-1:0]            sel,
  output logic [NS*SLICE-1:0]      result
);

  for (genvar k = 0; k < NS; k++) begin : g_mux
    assign result[k*SLICE +: SLICE] = sel[k] ? cand1[k] : cand0[k];
  end

endmodule

// File: rtl/sct_adder.sv
module sct_adder
  import sct_pkg::*;
#(
  parameter int WIDTH   = 108,
  parameter int SLICE   = 9,
  parameter int BLOCK   = 36,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NS   = WIDTH / SLICE;
  localparam int NSUB = BLOCK / SLICE;
  localparam int NB   = WIDTH / BLOCK;

  logic [NS-1:0][SLICE-1:0] cand0, cand1;
  sct_gp_t [NS-1:0]          slice_gp;
  logic [NS-1:0]             slice_cin;
  sct_gp_t [NB-1:0]          blk_gp;
  logic [NB:0]               blk_cin;
  logic [WIDTH-1:0]          sum_c;
  logic                      cout_c;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    sct_cond_sum #(.SLICE(SLICE)) u_cs (
      .a    (a[k*SLICE +: SLICE]),
      .b    (b[k*SLICE +: SLICE]),
      .sum0 (cand0[k]),
      .sum1 (cand1[k]),
      .grp  (slice_gp[k])
    );
  end

  assign blk_cin[0] = cin;

  for (genvar j = 0; j < NB; j++) begin : g_blk
    sct_lookahead_blk #(.NSUB(NSUB)) u_la (
      .sub_gp  (slice_gp[j*NSUB +: NSUB]),
      .blk_cin (blk_cin[j]),
      .sub_cin (slice_cin[j*NSUB +: NSUB]),
      .blk_gp  (blk_gp[j])
    );
    assign blk_cin[j+1] = sct_carry(blk_gp[j], blk_cin[j]);
  end

  assign cout_c = blk_cin[NB];

  sct_final_select #(.SLICE(SLICE), .NS(NS)) u_sel (
    .cand0  (cand0),
    .cand1  (cand1),
    .sel    (slice_cin),
    .result (sum_c)
  );

  // each sparse carry against a plain addition of the bits below it
  for (genvar k = 1; k < NS; k++) begin : g_chk_sparse
    logic [k*SLICE:0] low_sum;
    assign low_sum = {1'b0, a[k*SLICE-1:0]} + {1'b0, b[k*SLICE-1:0]} + {{(k*SLICE){1'b0}}, cin};
    always_comb begin
      AST_SPARSE_CARRY: assert (slice_cin[k] == low_sum[k*SLICE]); // R5
    end
  end

  always_comb begin
    AST_LOW_SLICE: assert (sum_c[SLICE-1:0] == (cin ? cand1[0] : cand0[0])); // R3
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= cout_c;
      end
    end

    AST_SUM_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> sum == $past(a + b + {{(WIDTH-1){1'b0}}, cin})); // R1
    AST_COUT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cout == $past(({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}) >> WIDTH)); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> (sum == '0) && !cout); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(a) && $stable(b) && $stable(cin) |=> $stable(sum)); // R9
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = cout_c;
  end

endmodule

// File: tb/sct_adder_bench.sv
module sct_adder_bench;

  localparam int WIDTH    = 108;
  localparam int SLICE    = 9;
  localparam int CLK_HALF = 5;
  localparam int WATCHDOG = 200000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic             cin = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [WIDTH:0] exp_prev;
  bit             have_prev = 1'b0;
  string          tag_prev;

  always #CLK_HALF clk = ~clk;

  sct_adder u_sct_adder (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic check_val(input string req, input logic [WIDTH:0] act, input logic [WIDTH:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] rnd108();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one operation per clock: check the previous result, then present new operands
  task automatic drive(input logic [WIDTH-1:0] na, input logic [WIDTH-1:0] nb,
                       input logic nc, input string req);
    @(negedge clk);
    if (have_prev) check_val(tag_prev, {cout, sum}, exp_prev);
    a = na; b = nb; cin = nc;
    #1;
    // R9: new operands must not reach the outputs before the next edge
    if (have_prev) check_val("R9", {cout, sum}, exp_prev);
    exp_prev  = {1'b0, na} + {1'b0, nb} + {{WIDTH{1'b0}}, nc};
    tag_prev  = req;
    have_prev = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_val("R7", {cout, sum}, '0);
    rst_n = 1'b1;

    // R3 / R4: lowest slice all ones, carry-in choosing candidate
    drive(108'h1FF, '0, 1'b0, "R3");
    drive(108'h1FF, '0, 1'b1, "R3");
    drive(108'h0AB, 108'h054, 1'b1, "R4");

    // R8: full-length propagate
    drive({WIDTH{1'b1}}, '0, 1'b1, "R8");
    drive('0, {WIDTH{1'b1}}, 1'b1, "R8");

    // R5: propagate run ending at each ninth bit
    for (int k = 1; k < WIDTH/SLICE; k++) begin
      logic [WIDTH-1:0] run;
      run = (108'd1 << (k*SLICE)) - 108'd1;
      drive(run, '0, 1'b1, (k % 4 == 0) ? "R6" : "R5");
      drive(108'd1 << (k*SLICE-1), 108'd1 << (k*SLICE-1), 1'b0, "R5");
    end

    // R6: carry generated low, propagated through a whole block
    drive((108'd1 << 72) - 108'd1, 108'd1, 1'b0, "R6");
    drive(108'hF_FFFF_FFFF << 36, (108'd1 << 35), 1'b0, "R6");

    // R1 / R2: random operands
    for (int i = 0; i < 300; i++) begin
      logic [WIDTH-1:0] ra, rb;
      ra = rnd108();
      rb = (i % 3 == 0) ? ~ra : rnd108();
      drive(ra, rb, 1'($urandom), (i % 2 == 0) ? "R1" : "R2");
    end

    drive('0, '0, 1'b0, "R1");
    @(negedge clk);
    check_val(tag_prev, {cout, sum}, exp_prev);

    // R7: reset asserted mid-run clears the result
    a = {WIDTH{1'b1}}; b = {WIDTH{1'b1}}; cin = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_val("R7", {cout, sum}, '0);
    @(negedge clk);
    check_val("R7", {cout, sum}, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule